// File: doc/BRIEF.md
# Multiplier-Cancelling Direct-Form FIR Filter

This block is a direct-form FIR filter whose coefficients are written one tap at a time while it runs. Each input sample arrives with a one-bit "small sample" tag from an upstream amplitude monitor. The tag is already aligned with its sample. Sample and tag move down the delay line together, and the tag is never altered on the way. Each tap also keeps a "coefficient small" flag. The flag is worked out at the moment the coefficient is written, never on every cycle.

When a tap holds a tagged sample and its coefficient is small, that tap's multiply is skipped. Its operand registers keep their old values, so the multiplier inputs do not toggle, and the tap adds exactly zero to the sum. This lowers the effective filter order depending on the data, with no change to the filter structure.

Each product is requantized to 16 bits. The requantized products are sign-extended and summed into a registered 24-bit result. The result comes with a valid flag three cycles after the sample is accepted.

Top module: `fir_mcancel_top`

## Requirements
- R1: While reset is asserted and until the first output, out_valid is 0 and out_data is 0. Every coefficient resets to 0, so a sample pushed before any coefficient write gives an output of 0.
- R2: A sample accepted with in_valid=1 at a rising edge makes out_valid 1 for exactly one cycle, starting just after the third rising edge counted from that acceptance edge.
- R3: For each accepted sample, out_data equals the sum over taps k=0..TAPS-1 of q(c_k, x_k). Here x_0 is the newest sample, x_k the sample accepted k pushes earlier, and q(c,x) is bits [30:15] of the 32-bit signed product c*x, taken as a signed 16-bit value.
- R4: Tap k contributes exactly zero when the tag travelling with x_k is 1 and its coefficient is small. While the tap is cancelled, its multiplier operand registers keep their previous values.
- R5: A coefficient is small when its magnitude is strictly below 2^-7, which is 256 in Q1.15. So the values -255..255 are small, and 256, -256 and anything larger in magnitude are not.
- R6: A tagged sample at a tap whose coefficient is not small is multiplied normally.
- R7: A tag affects only the tap its own sample occupies. It shifts down the line with the sample, and an untagged neighbour is never cancelled.
- R8: With in_valid=0 the delay line, tags and out_data hold, and no output is flagged.
- R9: A coefficient write (coef_we=1, coef_addr=k) is used for every sample accepted after the write edge. A write to an address of TAPS or above changes nothing.
- R10: out_data is the full 24-bit two's complement sum, correct for negative sums and for sums beyond the 16-bit range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Accept in_sample/in_tag this cycle |
| in_sample | input | 16 | Input sample, Q1.15 two's complement |
| in_tag | input | 1 | Small-sample tag aligned with in_sample |
| coef_we | input | 1 | Coefficient write strobe |
| coef_addr | input | $clog2(TAPS) | Tap index of the write |
| coef_data | input | 16 | Coefficient, Q1.15 two's complement |
| out_valid | output | 1 | out_data holds a new result |
| out_data | output | 24 | Filter output, two's complement |

## Verification
A wrong coefficient-small flag or a misplaced tag shows up as an output that differs from the reference sum by exactly one tap's product. The difference appears on the first sample that puts a tagged value on that tap, three cycles after it is accepted. Walking an impulse down the line, and sweeping coefficients across the ±256 edge with every sample tagged, isolates each tap's contribution in turn. A failure therefore points at the tap and the push where the state went wrong. Frozen operands cannot be seen at the ports, so they are checked by assertion on the tap registers.

// File: rtl/fir_mc_pkg.sv
package fir_mc_pkg;
  localparam int DATA_W = 16;
  localparam int COEF_W = 16;
  localparam int FRAC_W = 15;
  localparam int PROD_W = 16;
  localparam int FULL_W = DATA_W + COEF_W;

  // magnitude strictly below lim
  function automatic logic coef_is_small(input logic signed [COEF_W-1:0] c, input int lim);
    int v;
    v = int'(c);
    return (v < lim) && (v > -lim);
  endfunction

  // keep product bits [FRAC_W+PROD_W-1:FRAC_W], floor truncation
  function automatic logic signed [PROD_W-1:0] requant(input logic signed [DATA_W-1:0] x,
                                                       input logic signed [COEF_W-1:0] c);
    logic signed [FULL_W-1:0] p;
    p = x * c;
    return PROD_W'(p >>> FRAC_W);
  endfunction
endpackage

// File: rtl/fir_mc_coef_bank.sv
module fir_mc_coef_bank
  import fir_mc_pkg::*;
#(
  parameter int TAPS = 25,
  parameter int AW   = 5,
  parameter int LIM  = 256
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         we,
  input  logic [AW-1:0]                addr,
  input  logic [COEF_W-1:0]            data,
  output logic [TAPS-1:0][COEF_W-1:0]  coef_vec,
  output logic [TAPS-1:0]              small_vec
);
  for (genvar k = 0; k < TAPS; k++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        coef_vec[k]  <= '0;
        small_vec[k] <= 1'b1;
      end else if (we && addr == AW'(k)) begin
        coef_vec[k]  <= data;
        small_vec[k] <= coef_is_small(data, LIM);
      end
    end
  end
endmodule

// File: rtl/fir_mc_delay_line.sv
module fir_mc_delay_line
  import fir_mc_pkg::*;
#(
  parameter int TAPS = 25
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         adv,
  input  logic [DATA_W-1:0]            din,
  input  logic                         tin,
  output logic [TAPS-1:0][DATA_W-1:0]  x_vec,
  output logic [TAPS-1:0]              tag_vec,
  output logic                         line_valid
);
  for (genvar k = 0; k < TAPS; k++) begin : g_stage
    if (k == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          x_vec[k]   <= '0;
          tag_vec[k] <= 1'b0;
        end else if (adv) begin
          x_vec[k]   <= din;
          tag_vec[k] <= tin;
        end
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          x_vec[k]   <= '0;
          tag_vec[k] <= 1'b0;
        end else if (adv) begin
          x_vec[k]   <= x_vec[k-1];
          tag_vec[k] <= tag_vec[k-1];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) line_valid <= 1'b0;
    else        line_valid <= adv;
  end
endmodule

// File: rtl/fir_mc_tap.sv
module fir_mc_tap
  import fir_mc_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     adv,
  input  logic [DATA_W-1:0]        x,
  input  logic                     tag,
  input  logic [COEF_W-1:0]        c,
  input  logic                     c_small,
  output logic                     cancel_now,
  output logic [DATA_W-1:0]        op_x,
  output logic [COEF_W-1:0]        op_c,
  output logic [PROD_W-1:0]        prod
);
  logic kill_q;

  assign cancel_now = tag & c_small;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_x   <= '0;
      op_c   <= '0;
      kill_q <= 1'b1;
    end else if (adv) begin
      kill_q <= cancel_now;
      if (!cancel_now) begin
        op_x <= x;
        op_c <= c;
      end
    end
  end

  assign prod = kill_q ? '0 : requant(op_x, op_c);
endmodule

// File: rtl/fir_mc_sum.sv
module fir_mc_sum
  import fir_mc_pkg::*;
#(
  parameter int TAPS  = 25,
  parameter int OUT_W = 24
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         vin,
  input  logic [TAPS-1:0][PROD_W-1:0]  prod_vec,
  output logic                         vout,
  output logic [OUT_W-1:0]             dout
);
  logic [OUT_W-1:0] acc;

  always_comb begin
    acc = '0;
    for (int k = 0; k < TAPS; k++)
      acc = acc + {{(OUT_W-PROD_W){prod_vec[k][PROD_W-1]}}, prod_vec[k]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vout <= 1'b0;
      dout <= '0;
    end else begin
      vout <= vin;
      if (vin) dout <= acc;
    end
  end
endmodule

// File: rtl/fir_mcancel_top.sv
module fir_mcancel_top
  import fir_mc_pkg::*;
#(
  parameter int TAPS     = 25,
  parameter int OUT_W    = 24,
  parameter int CTH_LOG2 = 7,
  localparam int AW      = (TAPS > 1) ? $clog2(TAPS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [DATA_W-1:0]  in_sample,
  input  logic               in_tag,
  input  logic               coef_we,
  input  logic [AW-1:0]      coef_addr,
  input  logic [COEF_W-1:0]  coef_data,
  output logic               out_valid,
  output logic [OUT_W-1:0]   out_data
);
  localparam int LIM = 1 << (FRAC_W - CTH_LOG2);

  logic [TAPS-1:0][COEF_W-1:0] coef_vec;
  logic [TAPS-1:0]             small_vec;
  logic [TAPS-1:0][DATA_W-1:0] x_vec;
  logic [TAPS-1:0]             tag_vec;
  logic                        line_valid;
  logic                        prod_valid;
  logic [TAPS-1:0]             cancel_vec;
  logic [TAPS-1:0][DATA_W-1:0] opx_vec;
  logic [TAPS-1:0][COEF_W-1:0] opc_vec;
  logic [TAPS-1:0][PROD_W-1:0] prod_vec;

  fir_mc_coef_bank #(.TAPS(TAPS), .AW(AW), .LIM(LIM)) u_bank (
    .clk(clk), .rst_n(rst_n), .we(coef_we), .addr(coef_addr), .data(coef_data),
    .coef_vec(coef_vec), .small_vec(small_vec)
  );

  fir_mc_delay_line #(.TAPS(TAPS)) u_line (
    .clk(clk), .rst_n(rst_n), .adv(in_valid), .din(in_sample), .tin(in_tag),
    .x_vec(x_vec), .tag_vec(tag_vec), .line_valid(line_valid)
  );

  for (genvar k = 0; k < TAPS; k++) begin : g_tap
    fir_mc_tap u_tap (
      .clk(clk), .rst_n(rst_n), .adv(line_valid),
      .x(x_vec[k]), .tag(tag_vec[k]), .c(coef_vec[k]), .c_small(small_vec[k]),
      .cancel_now(cancel_vec[k]), .op_x(opx_vec[k]), .op_c(opc_vec[k]),
      .prod(prod_vec[k])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) prod_valid <= 1'b0;
    else        prod_valid <= line_valid;
  end

  fir_mc_sum #(.TAPS(TAPS), .OUT_W(OUT_W)) u_sum (
    .clk(clk), .rst_n(rst_n), .vin(prod_valid), .prod_vec(prod_vec),
    .vout(out_valid), .dout(out_data)
  );
endmodule

// File: rtl/fir_mc_checker.sv
module fir_mc_checker
  import fir_mc_pkg::*;
#(
  parameter int TAPS = 25,
  parameter int AW   = 5
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         in_valid,
  input logic                         in_tag,
  input logic                         coef_we,
  input logic [AW-1:0]                coef_addr,
  input logic [COEF_W-1:0]            coef_data,
  input logic                         out_valid,
  input logic                         line_valid,
  input logic [TAPS-1:0][DATA_W-1:0]  x_vec,
  input logic [TAPS-1:0]              tag_vec,
  input logic [TAPS-1:0]              cancel_vec,
  input logic [TAPS-1:0][DATA_W-1:0]  opx_vec,
  input logic [TAPS-1:0][COEF_W-1:0]  opc_vec,
  input logic [TAPS-1:0][COEF_W-1:0]  coef_vec
);
  AST_TAG_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> tag_vec[0] == $past(in_tag));                                 // R7
  AST_TAG_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> tag_vec[TAPS-1:1] == $past(tag_vec[TAPS-2:0]));                // R7
  AST_LINE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(x_vec) && $stable(tag_vec)));                        // R8
  AST_OUT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ##3 out_valid);                                                // R2
  AST_NO_SPURIOUS_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> ##3 !out_valid);                                              // R2

  for (genvar k = 0; k < TAPS; k++) begin : g_chk
    AST_OPERANDS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (line_valid && cancel_vec[k]) |=> ($stable(opx_vec[k]) && $stable(opc_vec[k]))); // R4
    AST_COEF_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (coef_we && coef_addr == AW'(k)) |=> coef_vec[k] == $past(coef_data));     // R9
  end
endmodule

bind fir_mcancel_top fir_mc_checker #(.TAPS(TAPS), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_tag(in_tag),
  .coef_we(coef_we), .coef_addr(coef_addr), .coef_data(coef_data),
  .out_valid(out_valid), .line_valid(line_valid), .x_vec(x_vec),
  .tag_vec(tag_vec), .cancel_vec(cancel_vec), .opx_vec(opx_vec),
  .opc_vec(opc_vec), .coef_vec(coef_vec)
);

// File: tb/test_fir_mcancel_top.sv
module test_fir_mcancel_top;
  localparam int TAPS = 25;
  localparam int AW   = $clog2(TAPS);
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [15:0] in_sample = '0;
  logic in_tag = 1'b0;
  logic coef_we = 1'b0;
  logic [AW-1:0] coef_addr = '0;
  logic [15:0] coef_data = '0;
  logic out_valid;
  logic [23:0] out_data;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  int cm [TAPS];
  int xm [TAPS];
  bit tm [TAPS];
  logic [15:0] lfsr = 16'hACE1;

  always #(CLK_PERIOD/2) clk = ~clk;

  fir_mcancel_top #(.TAPS(TAPS)) i_fir_mcancel_top (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
    .in_tag(in_tag), .coef_we(coef_we), .coef_addr(coef_addr),
    .coef_data(coef_data), .out_valid(out_valid), .out_data(out_data)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int q(input int c, input int x);
    int p;
    p = (c * x) >>> 15;
    p = p & 32'hFFFF;
    if (p >= 32768) p = p - 65536;
    return p;
  endfunction

  function automatic bit tiny(input int c);
    return ((c < 0) ? -c : c) < 256;
  endfunction

  function automatic int model_out();
    int s = 0;
    for (int k = 0; k < TAPS; k++)
      if (!(tm[k] && tiny(cm[k]))) s += q(cm[k], xm[k]);
    return s;
  endfunction

  function automatic int s16(input logic [15:0] v);
    return (v[15]) ? int'(v) - 65536 : int'(v);
  endfunction

  task automatic wr(input int addr, input int val);
    coef_we = 1'b1; coef_addr = AW'(addr); coef_data = 16'(val);
    @(negedge clk);
    coef_we = 1'b0;
    if (addr < TAPS) cm[addr] = s16(16'(val));
  endtask

  // push one sample and check the output 3 edges later
  task automatic push(input int x, input bit t, input string req);
    in_valid = 1'b1; in_sample = 16'(x); in_tag = t;
    for (int k = TAPS-1; k > 0; k--) begin xm[k] = xm[k-1]; tm[k] = tm[k-1]; end
    xm[0] = s16(16'(x)); tm[0] = t;
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    check({req, " valid early"}, int'(out_valid), 0);
    @(negedge clk);
    check({req, " out_valid"}, int'(out_valid), 1);
    check({req, " out_data"}, int'($signed(out_data)), model_out());
  endtask

  function automatic logic [15:0] step(input logic [15:0] v);
    return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < TAPS; k++) begin cm[k] = 0; xm[k] = 0; tm[k] = 0; end
    repeat (3) @(negedge clk);
    check("R1 reset out_valid", int'(out_valid), 0);
    check("R1 reset out_data", int'(out_data), 0);
    rst_n = 1'b1;
    @(negedge clk);
    push(16'h7000, 1'b0, "R1");

    // R3: distinct large coefficients, impulse walked down the line
    for (int k = 0; k < TAPS; k++) wr(k, (k + 1) * 1200 - 15000 + ((k % 2) ? 300 : -300));
    push(16'h4000, 1'b0, "R3 impulse");
    for (int i = 1; i < TAPS + 2; i++) push(0, 1'b0, "R3 impulse tail");
    push(16'h8000, 1'b0, "R3 min sample");

    // R8: idle keeps state, no output flagged
    repeat (5) begin
      @(negedge clk);
      check("R8 idle out_valid", int'(out_valid), 0);
    end
    check("R8 idle out_data", int'($signed(out_data)), model_out());
    push(1, 1'b0, "R8 resume");

    // R4 R6 R7: mixed small and large coefficients, random samples and tags
    for (int k = 0; k < TAPS; k++)
      wr(k, (k % 3 == 0) ? ((k * 37) % 255) - 120 : (k * 911) - 11000);
    for (int i = 0; i < 120; i++) begin
      lfsr = step(lfsr);
      push(int'(lfsr), lfsr[3] ^ lfsr[9], "R4 R6 R7 mixed");
    end
    // R7: single tagged sample between untagged ones
    for (int i = 0; i < TAPS; i++) push((i == 4) ? 16'h0123 : 16'h7abc, i == 4, "R7 lone tag");

    // R5: threshold boundary, every sample tagged
    for (int k = 0; k < TAPS; k++) begin
      case (k % 5)
        0: wr(k, 255);
        1: wr(k, -255);
        2: wr(k, 256);
        3: wr(k, -256);
        default: wr(k, 257);
      endcase
    end
    for (int i = 0; i < TAPS + 3; i++) push(16'h7fff, 1'b1, "R5 boundary");
    for (int i = 0; i < 10; i++) push(16'h8000, 1'b1, "R5 boundary neg");

    // R9: out-of-range writes ignored, in-range rewrite used by next sample
    for (int a = TAPS; a < (1 << AW); a++) wr(a, 16'h7fff);
    push(16'h7fff, 1'b0, "R9 ignored addr");
    wr(0, 20000);
    push(16'h7fff, 1'b0, "R9 rewrite");
    wr(3, 100);
    push(16'h6000, 1'b1, "R9 rewrite small");

    // R10: large negative and large positive sums
    for (int k = 0; k < TAPS; k++) wr(k, 16'h7fff);
    for (int i = 0; i < TAPS; i++) push(16'h8000, 1'b0, "R10 neg sum");
    check("R10 neg value", int'($signed(out_data)), -25 * 32767);
    for (int i = 0; i < TAPS; i++) push(16'h7fff, 1'b1, "R10 pos sum");

    // R2: single-cycle valid pulse
    @(negedge clk);
    check("R2 pulse width", int'(out_valid), 0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule